// File: doc/BRIEF.md
# Supply-Loss Write Guard

This block sits on the control path between a host memory bus and an SRAM array. It watches a digitized, already clock-synchronous supply-health flag. While the supply is good, it passes chip-select, write-strobe and output-enable straight through to the array. It also drives read data back to the host whenever a read is decoded.

When the supply flag reports a fault, new accesses are refused. An access that is already under way is allowed to finish, up to a bounded number of cycles. After that the array is locked, and all host controls are ignored while the read-data path is released (not driven).

Once the supply flag clears, the lock stays in force for a long, parameterized recovery interval so the host processor can settle. Only then does normal traffic resume. A sticky flag records that valid power has been seen at least once after reset, which arms battery retention for later power-downs.

Two comparator flags arrive at the block, one per supply-tolerance grade. A parameter chooses which of them counts. All intervals are counted in clock cycles.

Top module: `pf_guard`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `wp_status` is 1 and `bkup_en` is 0. In the same period `m_cs`, `m_we`, `m_oe` and `h_rd_en` are all 0.
- R2: When unlocked, the host controls (active low) decode to the array strobes as follows.
  - `h_cs_n`=1 gives no strobe.
  - `h_cs_n`=0 with `h_we_n`=0 gives a write (`m_we`=1).
  - `h_cs_n`=0, `h_we_n`=1, `h_oe_n`=0 gives a read (`m_oe`=1, `h_rd_en`=1, `h_rdata`=`m_rdata`).
  - `h_oe_n`=1 releases the data path.
- R3: If the selected fault flag is sampled high at a clock edge while no access is active (`h_cs_n`=1), `wp_status` is 1 after that edge.
- R4: While `wp_status` is 1, `m_cs`, `m_we`, `m_oe` and `h_rd_en` stay 0 whatever the host controls do, so no array location changes.
- R5: If the fault flag is sampled high while `h_cs_n`=0, the access keeps its strobes and `wp_status` stays 0 until `h_cs_n` rises. `wp_status` is 1 after the edge that samples `h_cs_n` high.
- R6: If the in-flight access is still active, strobes are forced off after `TMO_CYC` cycles counted from the edge that sampled the fault.
- R7: While locked, the first edge that samples the fault flag low starts recovery. `wp_status` falls exactly `REC_CYC` edges later if the flag stays low. After reset with the flag low, this takes `REC_CYC`+1 edges.
- R8: A fault sampled during recovery returns the block to the locked state. The next recovery then runs the full `REC_CYC` interval again.
- R9: `bkup_en` becomes 1 after the first edge out of reset that samples the selected fault flag low. It stays 1 until the next reset.
- R10: With `WIDE_TOL`=1 only `pf_lo10` is the fault flag and `pf_lo5` has no effect. With `WIDE_TOL`=0 the roles swap.
- R11: `wp_status` is 0 during normal operation and while an in-flight access is being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_lo5 | input | 1 | Fault flag, narrow-tolerance threshold |
| pf_lo10 | input | 1 | Fault flag, wide-tolerance threshold |
| h_cs_n | input | 1 | Host chip select, active low |
| h_we_n | input | 1 | Host write strobe, active low |
| h_oe_n | input | 1 | Host output enable, active low |
| h_addr | input | AW | Host address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Read data to host, zero when not driven |
| h_rd_en | output | 1 | Host data path driven (0 = high impedance) |
| m_cs | output | 1 | Array select, active high |
| m_we | output | 1 | Array write strobe, active high |
| m_oe | output | 1 | Array read strobe, active high |
| m_addr | output | AW | Array address |
| m_wdata | output | DW | Array write data |
| m_rdata | input | DW | Array read data |
| wp_status | output | 1 | Write protection in force |
| bkup_en | output | 1 | Sticky battery-retention arm flag |

## Verification
The bench builds the guard with a 4-bit address, a drain limit of 5 cycles, a recovery hold of 7 cycles and the wide-tolerance flag selected. The short intervals let it count every cycle of each drain and recovery window exactly, including the restart after a fault during recovery. The tiny address space lets it write and read back every location with an arithmetic pattern. The pattern makes any blocked or leaked write show up on readback.

// File: rtl/pf_guard.sv
module pf_guard #(
  parameter int AW       = 17,
  parameter int DW       = 8,
  parameter int TMO_CYC  = 12500,
  parameter int REC_CYC  = 10000000,
  parameter bit WIDE_TOL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_lo5,
  input  logic          pf_lo10,
  input  logic          h_cs_n,
  input  logic          h_we_n,
  input  logic          h_oe_n,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_rd_en,
  output logic          m_cs,
  output logic          m_we,
  output logic          m_oe,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  output logic          wp_status,
  output logic          bkup_en
);

  localparam int TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam int RW = (REC_CYC > 1) ? $clog2(REC_CYC) : 1;
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);
  localparam logic [RW-1:0] REC_LAST = RW'(REC_CYC - 1);

  typedef enum logic [1:0] {RUN = 2'd0, DRAIN = 2'd1, LOCK = 2'd2, HOLD = 2'd3} st_t;

  st_t st, nxt;
  logic [TW-1:0] tmo;
  logic [RW-1:0] rec;
  logic pf_sel, acc, pass;

  generate
    if (WIDE_TOL) begin : g_wide
      assign pf_sel = pf_lo10;
    end else begin : g_narrow
      assign pf_sel = pf_lo5;
    end
  endgenerate

  assign acc = ~h_cs_n;

  always_comb begin
    nxt = st;
    case (st)
      RUN:   if (pf_sel) nxt = acc ? DRAIN : LOCK;
      DRAIN: if (!acc || tmo == TMO_LAST) nxt = LOCK;
      LOCK:  if (!pf_sel) nxt = HOLD;
      HOLD:  if (pf_sel) nxt = LOCK;
             else if (rec == REC_LAST) nxt = RUN;
      default: nxt = LOCK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= LOCK;
      tmo     <= '0;
      rec     <= '0;
      bkup_en <= 1'b0;
    end else begin
      st  <= nxt;
      tmo <= (nxt == DRAIN && st == DRAIN) ? tmo + 1'b1 : '0;
      rec <= (nxt == HOLD && st == HOLD) ? rec + 1'b1 : '0;
      if (!pf_sel) bkup_en <= 1'b1;
    end
  end

  assign pass      = (st == RUN) || (st == DRAIN && acc);
  assign wp_status = (st == LOCK) || (st == HOLD);

  assign m_cs    = pass & acc;
  assign m_we    = m_cs & ~h_we_n;
  assign m_oe    = m_cs & h_we_n & ~h_oe_n;
  assign m_addr  = h_addr;
  assign m_wdata = h_wdata;
  assign h_rd_en = m_oe;
  assign h_rdata = h_rd_en ? m_rdata : '0;

endmodule

// File: rtl/pf_guard_chk.sv
module pf_guard_chk #(
  parameter int TMO_CYC = 4,
  parameter int REC_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pf,
  input logic [1:0] st,
  input logic       h_cs_n,
  input logic       m_cs,
  input logic       m_we,
  input logic       m_oe,
  input logic       h_rd_en,
  input logic       wp_status,
  input logic       bkup_en
);

  int dcnt, lcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= 0;
      lcnt <= 0;
    end else begin
      dcnt <= (st == 2'd1) ? dcnt + 1 : 0;
      lcnt <= (wp_status && !pf) ? lcnt + 1 : 0;
    end
  end

  // R4
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_status |-> (!m_cs && !m_we && !m_oe && !h_rd_en));

  // R3
  idle_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf && !wp_status && h_cs_n) |=> wp_status);

  // R5
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && h_cs_n) |=> wp_status);

  // R6
  drain_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (dcnt < TMO_CYC));

  // R7
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wp_status) |-> (lcnt == REC_CYC + 1));

  // R9
  bkup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(bkup_en));

endmodule

bind pf_guard pf_guard_chk #(.TMO_CYC(TMO_CYC), .REC_CYC(REC_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pf(pf_sel), .st(st), .h_cs_n(h_cs_n),
  .m_cs(m_cs), .m_we(m_we), .m_oe(m_oe), .h_rd_en(h_rd_en),
  .wp_status(wp_status), .bkup_en(bkup_en)
);

// File: tb/pf_guard_tb.sv
module pf_guard_tb;
  localparam int AW = 4, DW = 8, TMO = 5, REC = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pf_lo5 = 1'b0, pf_lo10 = 1'b0;
  logic h_cs_n = 1'b1, h_we_n = 1'b1, h_oe_n = 1'b1;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_wdata = '0;
  logic [DW-1:0] h_rdata, m_wdata, m_rdata;
  logic [AW-1:0] m_addr;
  logic h_rd_en, m_cs, m_we, m_oe, wp_status, bkup_en;
  logic [DW-1:0] mem [16];
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  pf_guard #(.AW(AW), .DW(DW), .TMO_CYC(TMO), .REC_CYC(REC), .WIDE_TOL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .pf_lo5(pf_lo5), .pf_lo10(pf_lo10),
    .h_cs_n(h_cs_n), .h_we_n(h_we_n), .h_oe_n(h_oe_n), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rd_en(h_rd_en), .m_cs(m_cs),
    .m_we(m_we), .m_oe(m_oe), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .wp_status(wp_status), .bkup_en(bkup_en));

  always @(posedge clk) if (m_we) mem[m_addr] <= m_wdata;
  assign m_rdata = mem[m_addr];

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 8'hff);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    h_addr = AW'(a); h_wdata = d; h_cs_n = 1'b0; h_we_n = 1'b0; h_oe_n = 1'b1;
    #1 check(m_we == 1'b1, "R2 write strobe", int'(m_we), 1);
    @(negedge clk);
    h_cs_n = 1'b1; h_we_n = 1'b1;
  endtask

  task automatic rd(input int a, input logic [7:0] exp, input string req);
    @(negedge clk);
    h_addr = AW'(a); h_cs_n = 1'b0; h_we_n = 1'b1; h_oe_n = 1'b0;
    #1;
    check(h_rd_en == 1'b1, req, int'(h_rd_en), 1);
    check(h_rdata == exp, req, int'(h_rdata), int'(exp));
    @(negedge clk);
    h_cs_n = 1'b1; h_oe_n = 1'b1;
  endtask

  task automatic wait_unlock(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (wp_status && n < 100);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(wp_status == 1'b1, "R1 wp", int'(wp_status), 1);
    check(bkup_en == 1'b0, "R1 bkup", int'(bkup_en), 0);
    check(!m_cs && !m_we && !m_oe && !h_rd_en, "R1 strobes", int'({m_cs, m_we, m_oe, h_rd_en}), 0);

    // R7 and R4 during first recovery, host hammering a write
    rst_n = 1'b1;
    h_addr = '0; h_wdata = 8'hEE; h_cs_n = 1'b0; h_we_n = 1'b0; h_oe_n = 1'b0;
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
      if (n == 1) check(bkup_en == 1'b1, "R9 bkup set", int'(bkup_en), 1);
      if (wp_status) check(!m_we && !h_rd_en, "R4 quiet in recovery", int'({m_we, h_rd_en}), 0);
    end while (wp_status && n < 100);
    h_cs_n = 1'b1; h_we_n = 1'b1; h_oe_n = 1'b1;
    check(n == REC + 1, "R7 reset hold length", n, REC + 1);
    check(wp_status == 1'b0, "R11 normal unlocked", int'(wp_status), 0);

    // R2 exhaustive write / readback sweep
    for (int a = 0; a < 16; a++) wr(a, pat(a));
    for (int a = 0; a < 16; a++) rd(a, pat(a), "R2 readback");
    @(negedge clk);
    h_cs_n = 1'b0; h_we_n = 1'b1; h_oe_n = 1'b1;
    #1 check(!h_rd_en && !m_oe, "R2 output disabled", int'({h_rd_en, m_oe}), 0);
    h_cs_n = 1'b1;
    #1 check(!m_cs && !h_rd_en, "R2 deselected", int'({m_cs, h_rd_en}), 0);

    // R10 narrow flag ignored
    @(negedge clk); pf_lo5 = 1'b1;
    @(negedge clk);
    check(wp_status == 1'b0, "R10 pf_lo5 ignored", int'(wp_status), 0);
    wr(3, 8'h5A);
    pf_lo5 = 1'b0;
    rd(3, 8'h5A, "R10 write accepted");

    // R3 idle lock, R4 blocked access
    @(negedge clk); pf_lo10 = 1'b1;
    @(negedge clk);
    check(wp_status == 1'b1, "R3 idle lock", int'(wp_status), 1);
    h_addr = 4'd3; h_wdata = 8'hA5; h_cs_n = 1'b0; h_we_n = 1'b0; h_oe_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!m_we && !m_cs && !h_rd_en, "R4 locked strobes", int'({m_cs, m_we, h_rd_en}), 0);
    end
    h_we_n = 1'b1;
    #1 check(!h_rd_en, "R4 locked read", int'(h_rd_en), 0);
    h_cs_n = 1'b1; h_oe_n = 1'b1;
    pf_lo10 = 1'b0;
    wait_unlock(n);
    check(n == REC + 1, "R7 hold length", n, REC + 1);
    rd(3, 8'h5A, "R4 location unchanged");

    // R8 fault during recovery restarts hold
    @(negedge clk); pf_lo10 = 1'b1;
    @(negedge clk); pf_lo10 = 1'b0;
    repeat (3) @(negedge clk);
    check(wp_status == 1'b1, "R8 still holding", int'(wp_status), 1);
    pf_lo10 = 1'b1;
    @(negedge clk);
    check(wp_status == 1'b1, "R8 relocked", int'(wp_status), 1);
    pf_lo10 = 1'b0;
    wait_unlock(n);
    check(n == REC + 1, "R8 full hold again", n, REC + 1);

    // R5 in-flight write drains
    @(negedge clk);
    h_addr = 4'd7; h_wdata = 8'h3C; h_cs_n = 1'b0; h_we_n = 1'b0; pf_lo10 = 1'b1;
    @(negedge clk);
    check(wp_status == 1'b0, "R11 drain unlocked", int'(wp_status), 0);
    check(m_we == 1'b1, "R5 drain keeps strobe", int'(m_we), 1);
    h_wdata = 8'hC3;
    @(negedge clk);
    check(m_we == 1'b1, "R5 drain second cycle", int'(m_we), 1);
    h_cs_n = 1'b1; h_we_n = 1'b1;
    @(negedge clk);
    check(wp_status == 1'b1, "R5 lock after end", int'(wp_status), 1);
    pf_lo10 = 1'b0;
    wait_unlock(n);
    rd(7, 8'hC3, "R5 drained write landed");

    // R6 drain timeout
    @(negedge clk);
    h_addr = 4'd9; h_wdata = 8'h99; h_cs_n = 1'b0; h_we_n = 1'b0; pf_lo10 = 1'b1;
    @(negedge clk);
    n = 0;
    while (m_we && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == TMO, "R6 drain cycles", n, TMO);
    check(wp_status == 1'b1, "R6 locked after timeout", int'(wp_status), 1);
    h_cs_n = 1'b1; h_we_n = 1'b1;
    pf_lo10 = 1'b0;
    wait_unlock(n);
    check(bkup_en == 1'b1, "R9 bkup sticky", int'(bkup_en), 1);
    rd(9, 8'h99, "R6 data written before cut");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule